// File: doc/BRIEF.md
# DMA Interrupt Mask Aggregator

This block gathers the interrupt sources of a multi-channel DMA engine into one interrupt line. Sources fall into three groups: transmit channels, receive channels and engine-level errors. Each group keeps a raw status vector, which follows level inputs from the channel engine, and a mask. The masked status is the raw vector ANDed with the mask. Software never writes a mask directly. It sets bits through one word offset and clears bits through another, so each channel driver can change its own bit without a read-modify-write.

A small state machine drives the interrupt line. In state ARMED it waits for any masked bit. It then enters PULSE, where `irq` is high for one cycle, and moves on to HELD. It leaves HELD, and also PULSE, only when software writes the end-of-interrupt word. The transitions are ARMED->PULSE on pending, PULSE->HELD without an acknowledge, PULSE->ARMED and HELD->ARMED on an acknowledge. If a condition is still pending after the acknowledge, the line pulses again. A vector word shows which groups hold pending masked bits.

Top module: `irqmask_ctrl`

## Requirements
- R1: After reset, every mask, every raw bit and `irq` are 0, and every mapped word reads 0.
- R2: A write to a mask-set word sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged. The mask-set words are at 0x88 (transmit), 0xA8 (receive) and 0xB8 (engine).
- R3: A write to a mask-clear word clears each mask bit whose data bit is 1. The mask-clear words are at 0x8C, 0xAC and 0xBC. Writing all ones clears the whole group.
- R4: Reading either the mask-set word or the mask-clear word of a group returns that group's current mask, zero-extended.
- R5: The raw word of a group returns the source inputs sampled at the previous clock edge. The raw words are at 0x80, 0xA0 and 0xB0. Writes to raw or masked words are ignored.
- R6: The masked word of a group returns raw AND mask. The masked words are at 0x84, 0xA4 and 0xB4.
- R7: When the machine is ARMED and any masked bit is set at a clock edge, `irq` is high for exactly one cycle starting at that edge.
- R8: After a pulse, `irq` stays low until a write of any value to 0x94. If a masked bit is still set after that write, `irq` pulses again.
- R9: The vector word at 0x90 reads bit 0 = any transmit masked bit, bit 1 = any receive masked bit, bit 2 = any engine masked bit, with all other bits 0.
- R10: The engine group is ERR_W bits wide, and bit 1 is the host error source. Mask bits above ERR_W are dropped on writes and read as 0. A raw bit whose mask bit is 0 never causes a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for bus_addr |
| tx_src | input | CH_N | Transmit channel status levels |
| rx_src | input | CH_N | Receive channel status levels |
| err_src | input | ERR_W | Engine error levels (bit 1 is host error) |
| irq | output | 1 | Interrupt pulse |

## Verification
Several stimulus patterns are applied. Overlapping set and clear data, with some bits already set, shows whether zero bits really leave the mask alone. A source that stays pending across many cycles separates a single pulse that waits for an acknowledge from a line that retriggers on its own. An acknowledge with the condition still present must produce a new pulse, while an acknowledge after an all-ones clear must not. Each group is exercised alone so that the vector bits and the per-group decode cannot be confused, and writes to the engine group above its width check that those bits are dropped.

// File: rtl/irqmask_pkg.sv
package irqmask_pkg;
    localparam logic [7:0] OFS_TX_PAGE  = 8'h80;
    localparam logic [7:0] OFS_RX_PAGE  = 8'hA0;
    localparam logic [7:0] OFS_ERR_PAGE = 8'hB0;
    localparam logic [7:0] OFS_VECTOR   = 8'h90;
    localparam logic [7:0] OFS_ACK      = 8'h94;

    typedef enum logic [1:0] {
        SLOT_RAW    = 2'd0,
        SLOT_MASKED = 2'd1,
        SLOT_SET    = 2'd2,
        SLOT_CLR    = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_PULSE = 2'd1,
        ST_HELD  = 2'd2
    } irq_state_e;
endpackage

// File: rtl/irqmask_group.sv
module irqmask_group
    import irqmask_pkg::*;
#(
    parameter int         W    = 8,
    parameter int         DW   = 32,
    parameter logic [7:0] PAGE = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  src,
    input  logic          wr,
    input  logic [7:0]    addr,
    input  logic [W-1:0]  wbits,
    output logic [W-1:0]  mask_o,
    output logic [W-1:0]  masked_o,
    output logic [DW-1:0] rdata
);
    localparam logic [3:0] PAGE_HI = PAGE[7:4];

    logic          sel;
    slot_e         slot;
    logic          set_stb;
    logic          clr_stb;
    logic [W-1:0]  raw_q;
    logic [W-1:0]  mask_q;

    assign sel     = (addr[7:4] == PAGE_HI) && (addr[1:0] == 2'b00);
    assign slot    = slot_e'(addr[3:2]);
    assign set_stb = wr && sel && (slot == SLOT_SET);
    assign clr_stb = wr && sel && (slot == SLOT_CLR);

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                raw_q[b]  <= 1'b0;
                mask_q[b] <= 1'b0;
            end else begin
                raw_q[b] <= src[b];
                if (set_stb && wbits[b]) begin
                    mask_q[b] <= 1'b1;
                end else if (clr_stb && wbits[b]) begin
                    mask_q[b] <= 1'b0;
                end
            end
        end
    end

    assign mask_o   = mask_q;
    assign masked_o = raw_q & mask_q;

    always_comb begin
        rdata = '0;
        if (sel) begin
            unique case (slot)
                SLOT_RAW:    rdata = DW'(raw_q);
                SLOT_MASKED: rdata = DW'(masked_o);
                SLOT_SET:    rdata = DW'(mask_q);
                SLOT_CLR:    rdata = DW'(mask_q);
            endcase
        end
    end
endmodule

// File: rtl/irqmask_fsm.sv
module irqmask_fsm
    import irqmask_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pending,
    input  logic       ack,
    output irq_state_e state_o,
    output logic       irq
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (pending) state_d = ST_PULSE;
            ST_PULSE: state_d = ack ? ST_ARMED : ST_HELD;
            ST_HELD:  if (ack) state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        irq = (state_q == ST_PULSE);
    end

    assign state_o = state_q;
endmodule

// File: rtl/irqmask_ctrl.sv
module irqmask_ctrl
    import irqmask_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CH_N  = 8,
    parameter int ERR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [CH_N-1:0]  tx_src,
    input  logic [CH_N-1:0]  rx_src,
    input  logic [ERR_W-1:0] err_src,
    output logic             irq
);
    logic [CH_N-1:0]  tx_mask, rx_mask, tx_masked, rx_masked;
    logic [ERR_W-1:0] err_mask, err_masked;
    logic [DW-1:0]    tx_rd, rx_rd, err_rd, vec_rd;
    logic             pending;
    logic             ack_wr;
    irq_state_e       irq_state;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata;

    irqmask_group #(.W(CH_N), .DW(DW), .PAGE(OFS_TX_PAGE)) u_tx (
        .clk(clk), .rst_n(rst_n), .src(tx_src), .wr(bus_wr), .addr(bus_addr),
        .wbits(bus_wdata[CH_N-1:0]), .mask_o(tx_mask), .masked_o(tx_masked),
        .rdata(tx_rd)
    );

    irqmask_group #(.W(CH_N), .DW(DW), .PAGE(OFS_RX_PAGE)) u_rx (
        .clk(clk), .rst_n(rst_n), .src(rx_src), .wr(bus_wr), .addr(bus_addr),
        .wbits(bus_wdata[CH_N-1:0]), .mask_o(rx_mask), .masked_o(rx_masked),
        .rdata(rx_rd)
    );

    irqmask_group #(.W(ERR_W), .DW(DW), .PAGE(OFS_ERR_PAGE)) u_err (
        .clk(clk), .rst_n(rst_n), .src(err_src), .wr(bus_wr), .addr(bus_addr),
        .wbits(bus_wdata[ERR_W-1:0]), .mask_o(err_mask), .masked_o(err_masked),
        .rdata(err_rd)
    );

    assign pending = (|tx_masked) || (|rx_masked) || (|err_masked);
    assign ack_wr  = bus_wr && (bus_addr == OFS_ACK);

    irqmask_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pending(pending), .ack(ack_wr),
        .state_o(irq_state), .irq(irq)
    );

    always_comb begin
        vec_rd = '0;
        if (bus_addr == OFS_VECTOR) begin
            vec_rd[0] = |tx_masked;
            vec_rd[1] = |rx_masked;
            vec_rd[2] = |err_masked;
        end
    end

    assign bus_rdata = tx_rd | rx_rd | err_rd | vec_rd;
endmodule

// File: rtl/irqmask_checks.sv
module irqmask_checks
    import irqmask_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CH_N  = 8,
    parameter int ERR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [CH_N-1:0]  tx_mask,
    input logic [CH_N-1:0]  rx_mask,
    input logic [ERR_W-1:0] err_mask,
    input logic             pending,
    input logic             ack_wr,
    input irq_state_e       irq_state,
    input logic             irq
);
    AST_TX_SET_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h88) |=> ((tx_mask & $past(bus_wdata[CH_N-1:0])) == $past(bus_wdata[CH_N-1:0]))); // R2
    AST_MASK_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(tx_mask) && $stable(rx_mask) && $stable(err_mask))); // R2
    AST_RX_CLR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'hAC) |=> ((rx_mask & $past(bus_wdata[CH_N-1:0])) == '0)); // R3
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(pending)); // R7
    AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_state == ST_HELD && !ack_wr) |=> !irq); // R8
endmodule

bind irqmask_ctrl irqmask_checks #(.DW(DW), .CH_N(CH_N), .ERR_W(ERR_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tx_mask(tx_mask), .rx_mask(rx_mask),
    .err_mask(err_mask), .pending(pending), .ack_wr(ack_wr),
    .irq_state(irq_state), .irq(irq)
);

// File: tb/irqmask_ctrl_test.sv
module irqmask_ctrl_test;
    localparam int DW = 32, CH_N = 8, ERR_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [7:0]       bus_addr = 8'h00;
    logic [DW-1:0]    bus_wdata = '0;
    logic [DW-1:0]    bus_rdata;
    logic [CH_N-1:0]  tx_src = '0, rx_src = '0;
    logic [ERR_W-1:0] err_src = '0;
    logic             irq;

    int tests = 0, fails = 0, pulses = 0;
    bit done = 0;

    // model state
    int m_mask[3];
    int m_raw[3];
    int m_st;   // 0 armed, 1 pulse, 2 held

    always #10 clk = ~clk;

    irqmask_ctrl #(.DW(DW), .CH_N(CH_N), .ERR_W(ERR_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_src(tx_src),
        .rx_src(rx_src), .err_src(err_src), .irq(irq)
    );

    function automatic int wmask(int g);
        return (g == 2) ? ((1 << ERR_W) - 1) : ((1 << CH_N) - 1);
    endfunction

    function automatic int grp_of(logic [7:0] a);
        if (a[1:0] != 2'b00) return -1;
        if (a[7:4] == 4'h8) return 0;
        if (a[7:4] == 4'hA) return 1;
        if (a[7:4] == 4'hB) return 2;
        return -1;
    endfunction

    function automatic logic [DW-1:0] mread(logic [7:0] a);
        int g;
        g = grp_of(a);
        if (g >= 0) begin
            case (a[3:2])
                2'd0: return DW'(m_raw[g]);
                2'd1: return DW'(m_raw[g] & m_mask[g]);
                default: return DW'(m_mask[g]);
            endcase
        end
        if (a == 8'h90) begin
            logic [DW-1:0] v;
            v = '0;
            for (int i = 0; i < 3; i++) v[i] = ((m_raw[i] & m_mask[i]) != 0);
            return v;
        end
        return '0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin m_mask[i] = 0; m_raw[i] = 0; end
            m_st = 0;
        end else begin
            bit pend, ack;
            int g;
            pend = 0;
            for (int i = 0; i < 3; i++) if ((m_raw[i] & m_mask[i]) != 0) pend = 1;
            ack = bus_wr && (bus_addr == 8'h94);
            case (m_st)
                0: if (pend) m_st = 1;
                1: m_st = ack ? 0 : 2;
                default: if (ack) m_st = 0;
            endcase
            g = grp_of(bus_addr);
            if (bus_wr && g >= 0) begin
                if (bus_addr[3:2] == 2'd2) m_mask[g] = m_mask[g] | (int'(bus_wdata) & wmask(g));
                if (bus_addr[3:2] == 2'd3) m_mask[g] = m_mask[g] & ~int'(bus_wdata);
            end
            m_raw[0] = int'(tx_src);
            m_raw[1] = int'(rx_src);
            m_raw[2] = int'(err_src);
        end
    end

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model (R7 pulse, R4/R5/R6/R9 reads)
    always begin
        @(negedge clk);
        #6;
        if (!done) begin
            chk("R7 irq vs model", {31'b0, irq}, {31'b0, (m_st == 1)});
            chk("R4 R5 R6 R9 rdata vs model", bus_rdata, mread(bus_addr));
            if (irq) pulses++;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic expect_rd(logic [7:0] a, logic [DW-1:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #4;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int p0;
        step(3);
        chk("R1 irq at reset", {31'b0, irq}, '0);
        rst_n = 1'b1;
        expect_rd(8'h88, 0, "R1 tx mask after reset");
        expect_rd(8'hB0, 0, "R1 err raw after reset");

        wr(8'h88, 32'h05);
        expect_rd(8'h88, 32'h05, "R2 set word");
        expect_rd(8'h8C, 32'h05, "R4 clear word reads mask");
        wr(8'h88, 32'h30);
        expect_rd(8'h88, 32'h35, "R2 zero bits unchanged");
        wr(8'h8C, 32'h01);
        expect_rd(8'h8C, 32'h34, "R3 clear one bit");

        p0 = pulses;
        tx_src = 8'h14;
        step(2);
        expect_rd(8'h80, 32'h14, "R5 raw follows source");
        expect_rd(8'h84, 32'h14, "R6 masked");
        expect_rd(8'h90, 32'h1, "R9 vector tx bit");
        wr(8'h80, 32'hFF);
        wr(8'h84, 32'hFF);
        expect_rd(8'h80, 32'h14, "R5 raw write ignored");
        step(20);
        chk("R7 one pulse per event", pulses - p0, 1);
        chk("R8 quiet before ack", {31'b0, irq}, '0);

        p0 = pulses;
        wr(8'h94, 32'h0);
        step(5);
        chk("R8 re-fire after ack", pulses - p0, 1);

        wr(8'h8C, 32'hFFFFFFFF);
        expect_rd(8'h88, 32'h0, "R3 all-ones clear");
        p0 = pulses;
        wr(8'h94, 32'h0);
        step(10);
        chk("R10 unmasked raw no pulse", pulses - p0, 0);
        tx_src = '0;

        p0 = pulses;
        wr(8'hA8, 32'h80);
        rx_src = 8'h80;
        step(3);
        expect_rd(8'h90, 32'h2, "R9 vector rx bit");
        expect_rd(8'hA4, 32'h80, "R6 rx masked");
        chk("R7 rx pulse", pulses - p0, 1);
        wr(8'hAC, 32'h80);
        rx_src = '0;

        wr(8'hB8, 32'hFF);
        expect_rd(8'hB8, 32'h3, "R10 bits above width dropped");
        wr(8'hBC, 32'h1);
        p0 = pulses;
        wr(8'h94, 32'h0);
        err_src = 2'b01;
        step(4);
        chk("R10 masked-off err bit no pulse", pulses - p0, 0);
        err_src = 2'b10;
        step(3);
        expect_rd(8'hB0, 32'h2, "R10 host error raw");
        expect_rd(8'h90, 32'h4, "R9 vector err bit");
        chk("R10 host error pulse", pulses - p0, 1);

        wr(8'h94, 32'h0);
        wr(8'h94, 32'h0);
        step(4);
        finish_run();
    end
endmodule